// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

The arbiter takes seven request lines, one for each priority level from 1 to 7, and the 3-bit interrupt mask held in a processor status register. It reports whether any request is currently allowed through, and which level that request has. There are eight levels, 0 to 7, and 7 is the most urgent. Level 0 stands for "no interrupt": a mask of 0 lets every level through.

A request at levels 1 to 6 gets through only when its level is strictly above the mask. Requests at or below the mask are dropped. These six lines are sensed by level and are not stored, so a line that falls stops counting at the next clock.

Level 7 cannot be masked. It is honoured even while software holds the mask at 7 to guard a critical section; software restores the previous mask value afterwards. Level 7 is taken on the rising edge of its line and stored until the processor pulses the acknowledge input. A line held high therefore raises one interrupt and no more.

Both outputs are registered. Each follows the inputs by one clock.

Top module: `pil_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next values of `pend_o` and `level_o` are 0. Reset also clears the stored level-7 request and the edge history, so after reset a line that is already high counts as a new edge.
- R2: With no request taken, `pend_o` is 0 and `level_o` is 0.
- R3: A request on `irq_i[L]`, for L from 1 to 6, is taken when L is greater than `mask_i`. `level_o` is the binary value of L. A mask of 0 enables all levels.
- R4: A request on `irq_i[L]`, for L from 1 to 6, has no effect when L is less than or equal to `mask_i`. This includes the case where L equals the mask.
- R5: When several requests are taken, `level_o` is the highest of them. A stored level-7 request beats every lower level.
- R6: A level-7 request is taken whatever the value of `mask_i`, including a mask of 7.
- R7: A rising edge on `irq_i[7]` stores a level-7 request, which stays pending while no acknowledge arrives. Keeping the line high after an acknowledge does not store a new request.
- R8: `ack_i` clears a stored level-7 request at that clock edge. It has no effect on requests at levels 1 to 6.
- R9: Requests at levels 1 to 6 are not stored. When the line drops, the request is gone one clock later.
- R10: `pend_o` and `level_o` change exactly one clock after the inputs that cause the change. Before that edge they keep their old values.
- R11: A rising edge on `irq_i[7]` in the same cycle as `ack_i` stores the new request. An `ack_i` that arrives while no level-7 request is stored has no effect.
- R12: A level-7 pulse that lasts one cycle is stored and stays pending after the line returns low, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_i | input | 7 | Request lines. Bit L carries the request for level L, with bits 7 down to 1 |
| mask_i | input | 3 | Current interrupt mask from the status register |
| ack_i | input | 1 | Acknowledge; consumes a stored level-7 request |
| pend_o | output | 1 | An allowed request exists (registered) |
| level_o | output | 3 | Level of the highest allowed request, or 0 when there is none (registered) |

## Verification
The bench targets the following corner cases; each wrong design below would fail it:

| Corner case | What a wrong design would do |
|---|---|
| A request whose level equals the mask | A design that compares with greater-or-equal would take it |
| A mask of 7 during a critical section | A design that masks level 7 would lose it |
| Level 7 held high across an acknowledge | A level-sensitive design would fire again at once |
| A one-cycle level-7 pulse | A design without the stored request would forget it |
| An edge that meets an acknowledge in the same cycle | A design that gives the acknowledge priority would drop the new edge |
| An acknowledge while only a lower level is active | A design that lets it reach levels 1 to 6 would drop that request |
| Output timing | A stage too many or too few shows up as an output one cycle late or early |

// File: rtl/pil_pkg.sv
// Package: shared sizing for the priority interrupt level arbiter.
// Assumes a binary level code in which the top code is the non-maskable level.
package pil_pkg;
    parameter int unsigned PIL_LVL_W = 3;
endpackage

// File: rtl/pil_top_edge.sv
// Module: capture of the top (non-maskable) request on a rising edge.
// A rising edge stores a request. An acknowledge clears it, but a new edge in
// the same cycle wins. take_o is the value the store will hold after this edge,
// so the output stage sees the top level in the same clock as the input edge.
// Assumes req_i is synchronous to clk.
module pil_top_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    output logic take_o
);
    logic prev_q;
    logic held_q;
    logic rise;

    // new edge on the top request line
    assign rise   = req_i && !prev_q;
    // top request counts this cycle: fresh edge, or stored and not being acknowledged
    assign take_o = rise || (held_q && !ack_i);

    // edge history and stored request, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            held_q <= take_o;
        end
    end

    // R7
    held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !ack_i) |=> held_q);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !req_i) |=> !held_q);

    // R7
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_i && prev_q) |=> !held_q);
endmodule

// File: rtl/pil_select.sv
// Module: mask qualification and priority choice (combinational).
// Each lower level is allowed only when it is strictly above the mask. The top
// level bypasses the mask. The highest allowed level wins, and 0 means none.
// Assumes the top level is the all-ones code of LVL_W bits.
module pil_select #(
    parameter int unsigned LVL_W = pil_pkg::PIL_LVL_W,
    localparam int unsigned TOP  = (1 << LVL_W) - 1
) (
    input  logic [TOP-1:1]   req_low_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             take_top_i,
    output logic             any_o,
    output logic [LVL_W-1:0] lvl_o
);
    logic [TOP-1:1] qual;

    // one strict compare per lower level
    for (genvar g = 1; g < TOP; g++) begin : g_qual
        assign qual[g] = req_low_i[g] && (LVL_W'(g) > mask_i);
    end

    // highest allowed level wins, and the top level overrides all
    always_comb begin
        lvl_o = '0;
        for (int i = 1; i < TOP; i++) begin
            if (qual[i]) lvl_o = LVL_W'(i);
        end
        if (take_top_i) lvl_o = LVL_W'(TOP);
        any_o = take_top_i || (|qual);
    end
endmodule

// File: rtl/pil_arbiter.sv
// Module: priority interrupt level arbiter (top).
// Combines the top-level edge capture with the mask and priority choice, and
// registers the pending flag and level so they follow the inputs by one clock.
// Assumes all inputs are synchronous to clk; the reset is synchronous and active low.
module pil_arbiter #(
    parameter int unsigned LVL_W = pil_pkg::PIL_LVL_W,
    localparam int unsigned TOP  = (1 << LVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOP:1]     irq_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             ack_i,
    output logic             pend_o,
    output logic [LVL_W-1:0] level_o
);
    logic             take_top;
    logic             any_n;
    logic [LVL_W-1:0] lvl_n;

    pil_top_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_i[TOP]),
        .ack_i  (ack_i),
        .take_o (take_top)
    );

    pil_select #(.LVL_W(LVL_W)) u_sel (
        .req_low_i  (irq_i[TOP-1:1]),
        .mask_i     (mask_i),
        .take_top_i (take_top),
        .any_o      (any_n),
        .lvl_o      (lvl_n)
    );

    // output register for the pending flag and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o  <= 1'b0;
            level_o <= '0;
        end else begin
            pend_o  <= any_n;
            level_o <= lvl_n;
        end
    end

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (level_o == '0));

    // R4
    above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> ((level_o == LVL_W'(TOP)) || (level_o > $past(mask_i))));

    // R6
    top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_top |=> (pend_o && level_o == LVL_W'(TOP)));

    // R9
    not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_top && irq_i[TOP-1:1] == '0) |=> !pend_o);
endmodule

// File: tb/tb_pil_arbiter.sv
module tb_pil_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:1] irq_i = '0;
    logic [2:0] mask_i = '0;
    logic       ack_i = 1'b0;
    logic       pend_o;
    logic [2:0] level_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       pend;
        logic [2:0] lvl;
        string      tag;
    } exp_t;
    exp_t q[$];

    pil_arbiter dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_i(mask_i),
        .ack_i(ack_i), .pend_o(pend_o), .level_o(level_o)
    );

    always #10 clk = ~clk;

    // driver: apply one cycle of inputs, queue the result due after the next edge
    task automatic step(input logic r, input logic [7:1] irq, input logic [2:0] m,
                        input logic a, input logic ep, input logic [2:0] el,
                        input string tag);
        @(negedge clk);
        rst_n = r; irq_i = irq; mask_i = m; ack_i = a;
        q.push_back('{pend: ep, lvl: el, tag: tag});
    endtask

    // monitor: compare the outputs shortly after each edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (pend_o !== e.pend || level_o !== e.lvl) begin
                bad++;
                $display("FAIL %s: pend=%0b level=%0d expected pend=%0b level=%0d",
                         e.tag, pend_o, level_o, e.pend, e.lvl);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(1'b0, 7'h7F, 3'd0, 1'b0, 1'b0, 3'd0, "R1 reset");
        step(1'b0, 7'h00, 3'd0, 1'b0, 1'b0, 3'd0, "R1 reset");
        step(1'b1, 7'h00, 3'd0, 1'b0, 1'b0, 3'd0, "R2 idle");
        step(1'b1, 7'b0000100, 3'd0, 1'b0, 1'b1, 3'd3, "R3 mask0");
        step(1'b1, 7'b0000100, 3'd2, 1'b0, 1'b1, 3'd3, "R3 above");
        step(1'b1, 7'b0000100, 3'd3, 1'b0, 1'b0, 3'd0, "R4 equal");
        step(1'b1, 7'b0101010, 3'd5, 1'b0, 1'b1, 3'd6, "R5 highest");
        step(1'b1, 7'b0101010, 3'd6, 1'b0, 1'b0, 3'd0, "R4 below");
        step(1'b1, 7'b0001010, 3'd0, 1'b0, 1'b1, 3'd4, "R5 pick4");
        step(1'b1, 7'b0001010, 3'd0, 1'b1, 1'b1, 3'd4, "R8 ack low");
        step(1'b1, 7'h00, 3'd0, 1'b0, 1'b0, 3'd0, "R9 drop");
        step(1'b1, 7'b1000000, 3'd7, 1'b0, 1'b1, 3'd7, "R6 mask7");
        step(1'b1, 7'b1000000, 3'd7, 1'b0, 1'b1, 3'd7, "R7 held");
        step(1'b1, 7'b1000000, 3'd7, 1'b1, 1'b0, 3'd0, "R8 ack");
        step(1'b1, 7'b1000000, 3'd7, 1'b0, 1'b0, 3'd0, "R7 no retrigger");
        step(1'b1, 7'h00, 3'd0, 1'b1, 1'b0, 3'd0, "R11 ack idle");
        step(1'b1, 7'b1010000, 3'd0, 1'b0, 1'b1, 3'd7, "R5 top beats");
        step(1'b1, 7'b0010000, 3'd0, 1'b0, 1'b1, 3'd7, "R12 pulse kept");
        step(1'b1, 7'b0010000, 3'd0, 1'b1, 1'b1, 3'd5, "R8 ack to low");
        step(1'b1, 7'b1000000, 3'd0, 1'b1, 1'b1, 3'd7, "R11 edge+ack");
        step(1'b1, 7'b1000000, 3'd0, 1'b0, 1'b1, 3'd7, "R11 kept");
        step(1'b1, 7'h00, 3'd0, 1'b1, 1'b0, 3'd0, "R8 ack clear");
        step(1'b1, 7'b0100000, 3'd7, 1'b0, 1'b0, 3'd0, "R4 critical");
        step(1'b1, 7'b0100000, 3'd6, 1'b0, 1'b0, 3'd0, "R4 eq6");
        step(1'b1, 7'b0100000, 3'd5, 1'b0, 1'b1, 3'd6, "R3 restore");
        // R10: a new input must not show before the next edge
        @(negedge clk);
        irq_i = 7'b0000001; mask_i = 3'd0; ack_i = 1'b0;
        q.push_back('{pend: 1'b1, lvl: 3'd1, tag: "R10 after edge"});
        #2;
        total++;
        if (level_o !== 3'd6) begin
            bad++;
            $display("FAIL R10 early: level=%0d expected 6", level_o);
        end
        step(1'b1, 7'h00, 3'd0, 1'b0, 1'b0, 3'd0, "R9 gone");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule